// File: doc/BRIEF.md
# Slave Status Indicator Controller

This block turns a handful of status conditions of a field-bus slave into the drive pattern for a pair of indicator LEDs, one green and one red. The condition inputs are the supply-present flag, a flag for an externally forced reset or a field-supply overload shutdown, an active-low peripheral fault line, an address-is-zero flag and a flag that says the communication watchdog has expired. The block picks the most urgent of these and shows its pattern. A pattern is steady on, steady off, a single blinking LED, or both LEDs blinking in turn.

The blink rate comes from a free-running divider. By default it is 2.5 Hz with an even duty cycle on a 5.333 MHz clock, so each half period lasts 1,066,667 cycles. Only the hard reset `rst_n` clears this divider. A soft reset of the surrounding slave shows up here as the reset/overload condition, and it changes only which pattern is shown. The blink phase keeps running through it.

The two outputs are registered drive enables for the open-drain LED switches. A 1 turns the switch on and lights the LED. Each output changes only on a clock edge, one cycle after the inputs that cause the change.

Top module: `led_status_ctrl`

## Requirements
- R1: While `rst_n` is low, and for the first two clock edges after it rises, both `led_grn` and `led_red` are 0.
- R2: When `supply_ok` is 0, both LEDs are dark on the following cycle, whatever the other inputs are.
- R3: When the supply is present and `ext_rst_ovl` is 1, the next cycle shows green dark and red lit steadily. This takes priority over every lower condition.
- R4: When the supply is present, `ext_rst_ovl` is 0 and `periph_fault_n` is 0, green is dark and red follows the blink phase.
- R5: When the supply is present, neither of the two conditions above holds, and `addr_zero` is 1, the LEDs alternate: green is lit while the phase is 0, and red is lit while the phase is 1.
- R6: When the supply is present, no higher condition holds and `wdog_expired` is 1, green is dark and red is lit steadily.
- R7: When the supply is present and no condition is active, green is lit and red is dark.
- R8: The blink phase is 0 for the first `HALF_CYCLES` active edges after reset, then changes every `HALF_CYCLES` edges. An active edge is any edge from the third edge after `rst_n` rises onwards.
- R9: Only `rst_n` restarts the blink phase. Dwelling in any condition, including the reset/overload condition, leaves it running.
- R10: The two LEDs are never lit at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 5.333 MHz nominal |
| rst_n | input | 1 | Hard reset, asynchronous assert, active low |
| supply_ok | input | 1 | 1 when the slave supply is present |
| ext_rst_ovl | input | 1 | 1 during external reset or field-supply overload |
| periph_fault_n | input | 1 | 0 when the peripheral circuitry reports a fault |
| addr_zero | input | 1 | 1 when the slave holds the default address zero |
| wdog_expired | input | 1 | 1 when the communication watchdog has expired |
| led_grn | output | 1 | Green switch enable, 1 = lit |
| led_red | output | 1 | Red switch enable, 1 = lit |

## Verification
The bench builds the block with `HALF_CYCLES` set to 5 instead of the default of more than a million. This makes phase boundaries come every few cycles, so a short run crosses many of them. It covers phase edges that fall inside a dwell in each condition and condition changes that land on a boundary. It also shows that a second hard reset restarts the phase while the reset/overload condition does not.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

  typedef enum logic [2:0] {
    ST_NOSUP   = 3'd0,
    ST_EXTRST  = 3'd1,
    ST_FAULT   = 3'd2,
    ST_ADDR0   = 3'd3,
    ST_NOCOMM  = 3'd4,
    ST_REGULAR = 3'd5
  } led_state_e;

  typedef struct packed {
    logic grn;
    logic red;
  } led_pair_t;

endpackage

// File: rtl/led_prio_enc.sv
module led_prio_enc
  import led_status_pkg::*;
(
  input  logic       supply_ok,
  input  logic       ext_rst_ovl,
  input  logic       periph_fault_n,
  input  logic       addr_zero,
  input  logic       wdog_expired,
  output led_state_e state_o
);

  always_comb begin
    if (!supply_ok)           state_o = ST_NOSUP;
    else if (ext_rst_ovl)     state_o = ST_EXTRST;
    else if (!periph_fault_n) state_o = ST_FAULT;
    else if (addr_zero)       state_o = ST_ADDR0;
    else if (wdog_expired)    state_o = ST_NOCOMM;
    else                      state_o = ST_REGULAR;
  end

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
  parameter int HALF_CYCLES = 1066667,
  parameter int CW          = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_o,
  output logic          phase_o
);

  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;
  logic          wrap;

  always_comb begin
    wrap    = (cnt_q == LAST);
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    phase_d = wrap ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/led_pattern_map.sv
module led_pattern_map
  import led_status_pkg::*;
(
  input  led_state_e state_i,
  input  logic       phase_i,
  output led_pair_t  leds_o
);

  always_comb begin
    unique case (state_i)
      ST_NOSUP:   leds_o = '{grn: 1'b0,     red: 1'b0};
      ST_EXTRST:  leds_o = '{grn: 1'b0,     red: 1'b1};
      ST_FAULT:   leds_o = '{grn: 1'b0,     red: phase_i};
      ST_ADDR0:   leds_o = '{grn: ~phase_i, red: phase_i};
      ST_NOCOMM:  leds_o = '{grn: 1'b0,     red: 1'b1};
      ST_REGULAR: leds_o = '{grn: 1'b1,     red: 1'b0};
      default:    leds_o = '{grn: 1'b0,     red: 1'b0};
    endcase
  end

endmodule

// File: rtl/led_status_ctrl.sv
module led_status_ctrl
  import led_status_pkg::*;
#(
  parameter int HALF_CYCLES = 1066667,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic ext_rst_ovl,
  input  logic periph_fault_n,
  input  logic addr_zero,
  input  logic wdog_expired,
  output logic led_grn,
  output logic led_red
);

  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;

  // reset: asynchronous assertion, synchronous release
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  led_state_e    cur_state;
  logic [CW-1:0] blink_cnt;
  logic          blink_phase;
  led_pair_t     leds_d, leds_q;

  led_prio_enc u_prio (
    .supply_ok      (supply_ok),
    .ext_rst_ovl    (ext_rst_ovl),
    .periph_fault_n (periph_fault_n),
    .addr_zero      (addr_zero),
    .wdog_expired   (wdog_expired),
    .state_o        (cur_state)
  );

  led_blink_gen #(.HALF_CYCLES(HALF_CYCLES), .CW(CW)) u_blink (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cnt_o   (blink_cnt),
    .phase_o (blink_phase)
  );

  led_pattern_map u_map (
    .state_i (cur_state),
    .phase_i (blink_phase),
    .leds_o  (leds_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) leds_q <= '0;
    else             leds_q <= leds_d;
  end

  assign led_grn = leds_q.grn;
  assign led_red = leds_q.red;

endmodule

// File: rtl/led_status_chk.sv
module led_status_chk #(
  parameter int HALF_CYCLES = 1066667,
  parameter int CW          = 1
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          supply_ok,
  input logic          ext_rst_ovl,
  input logic          periph_fault_n,
  input logic          addr_zero,
  input logic          wdog_expired,
  input logic [CW-1:0] blink_cnt,
  input logic          blink_phase,
  input logic          led_grn,
  input logic          led_red
);

  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  assert_nosupply_dark_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !supply_ok |=> (!led_grn && !led_red));

  assert_extrst_red_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (supply_ok && ext_rst_ovl) |=> (!led_grn && led_red));

  assert_fault_blink_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (supply_ok && !ext_rst_ovl && !periph_fault_n) |=> (!led_grn && (led_red == $past(blink_phase))));

  assert_addr0_alt_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (supply_ok && !ext_rst_ovl && periph_fault_n && addr_zero) |=> (led_grn != led_red));

  assert_nocomm_red_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (supply_ok && !ext_rst_ovl && periph_fault_n && !addr_zero && wdog_expired) |=> (!led_grn && led_red));

  assert_regular_green_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (supply_ok && !ext_rst_ovl && periph_fault_n && !addr_zero && !wdog_expired) |=> (led_grn && !led_red));

  assert_phase_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (blink_cnt != LAST) |=> $stable(blink_phase));

  assert_phase_flip_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (blink_cnt == LAST) |=> (blink_phase != $past(blink_phase)));

  assert_never_both_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(led_grn && led_red));

endmodule

bind led_status_ctrl led_status_chk #(.HALF_CYCLES(HALF_CYCLES), .CW(CW)) u_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .supply_ok      (supply_ok),
  .ext_rst_ovl    (ext_rst_ovl),
  .periph_fault_n (periph_fault_n),
  .addr_zero      (addr_zero),
  .wdog_expired   (wdog_expired),
  .blink_cnt      (blink_cnt),
  .blink_phase    (blink_phase),
  .led_grn        (led_grn),
  .led_red        (led_red)
);

// File: tb/sim_led_status_ctrl.sv
module sim_led_status_ctrl;

  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, ext_rst_ovl = 1'b0, periph_fault_n = 1'b1;
  logic addr_zero = 1'b0, wdog_expired = 1'b0;
  logic led_grn, led_red;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  led_status_ctrl #(.HALF_CYCLES(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ext_rst_ovl(ext_rst_ovl),
    .periph_fault_n(periph_fault_n), .addr_zero(addr_zero), .wdog_expired(wdog_expired),
    .led_grn(led_grn), .led_red(led_red)
  );

  // behavioural reference: edges since reset release, phase from time only
  int    edges_since = 0;
  logic  exp_g = 1'b0, exp_r = 1'b0;
  string exp_tag = "R1";
  string tag_override = "";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges_since = 0;
      exp_g = 0; exp_r = 0; exp_tag = "R1";
    end else begin
      if (edges_since < 2) begin
        exp_g = 0; exp_r = 0; exp_tag = "R1";
      end else begin
        int ph;
        ph = ((edges_since - 2) / HALF) % 2;
        if (!supply_ok)           begin exp_g = 0; exp_r = 0; exp_tag = "R2"; end
        else if (ext_rst_ovl)     begin exp_g = 0; exp_r = 1; exp_tag = "R3"; end
        else if (!periph_fault_n) begin exp_g = 0; exp_r = ph[0]; exp_tag = "R4/R8"; end
        else if (addr_zero)       begin exp_g = ~ph[0]; exp_r = ph[0]; exp_tag = "R5/R8"; end
        else if (wdog_expired)    begin exp_g = 0; exp_r = 1; exp_tag = "R6"; end
        else                      begin exp_g = 1; exp_r = 0; exp_tag = "R7"; end
        if (tag_override != "") exp_tag = tag_override;
      end
      edges_since++;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (led_grn !== exp_g || led_red !== exp_r) begin
        errors++;
        $display("FAIL %s grn/red actual %b%b expected %b%b at %0t",
                 exp_tag, led_grn, led_red, exp_g, exp_r, $time);
      end
      checks++;
      if (led_grn === 1'b1 && led_red === 1'b1) begin
        errors++;
        $display("FAIL R10 grn/red actual 11 expected not both lit at %0t", $time);
      end
    end
  end

  task automatic apply(input logic s, input logic e, input logic f_n,
                       input logic a, input logic w, input int n);
    @(negedge clk);
    #1;
    supply_ok = s; ext_rst_ovl = e; periph_fault_n = f_n; addr_zero = a; wdog_expired = w;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    // R1: reset state, with conditions that would otherwise light green
    supply_ok = 1;
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    repeat (12) @(negedge clk);
    apply(0, 1, 0, 1, 1, 6);   // R2 supply off dominates
    apply(1, 1, 0, 1, 1, 8);   // R3 ext reset dominates
    apply(1, 0, 0, 1, 1, 23);  // R4 fault blink over several boundaries
    apply(1, 0, 1, 1, 1, 23);  // R5 alternating blink
    apply(1, 0, 1, 0, 1, 9);   // R6 no communication
    apply(1, 0, 1, 0, 0, 9);   // R7 regular
    // R9: dwell in ext reset across boundaries, then fault keeps phase
    tag_override = "R9";
    apply(1, 1, 1, 0, 0, 13);
    apply(1, 0, 0, 0, 0, 17);
    apply(1, 1, 0, 0, 0, 3);
    apply(1, 0, 1, 1, 0, 14);
    tag_override = "";
    // rapid changes landing on and around boundaries
    for (int k = 0; k < 40; k++)
      apply(1'b1, (k % 7) == 0, (k % 3) != 0, (k % 2) == 0, (k % 5) != 1, 1 + (k % 4));
    // R8: second hard reset restarts the phase
    @(negedge clk); #1 rst_n = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1; supply_ok = 1; ext_rst_ovl = 0; periph_fault_n = 0;
    repeat (24) @(negedge clk);
    periph_fault_n = 1; addr_zero = 1;
    repeat (12) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule